// File: doc/BRIEF.md
# Pipelined Modulo-257 Number-Theoretic Transform

This block computes a 64-point number-theoretic transform over the integers modulo 257 at a rate of one block per clock. Each input block is 64 bits wide. Bit j is a coefficient x_j that is either 0 or 1. The block applies a pre-twist by powers of omega = 42, which is a primitive 128th root of unity modulo 257. It then runs a six-stage radix-2 decimation-in-frequency pipeline using omega squared as the 64th root. Every lane k of the result holds Y_k = sum over j of x_j * omega^((2k+1)j) mod 257.

All values are carried as a zero flag plus an 8-bit field. For a nonzero value v the field holds v-1. The twiddle multiplies are constant mappings whose contents are derived at elaboration, so no general multiplier exists in the datapath. The output lanes are rearranged in the wiring so that they appear in natural index order.

A valid/ready pair sits at each end of the block. Each pipeline register advances on its own when the next one is free, so bubbles collapse under back-pressure.

Top module: `ntt257_pipe`

## Requirements
- R1: A residue v is encoded as zero flag 0 with field v-1 when v is nonzero, and as zero flag 1 with field 0 when v is zero. Every output lane follows this encoding.
- R2: For an accepted block with bits x_j, output lane k carries Y_k = sum over j of x_j * 42^((2k+1)j) mod 257. The field of lane k is out_dim[8k+7:8k] and its zero flag is out_zero[k].
- R3: A block accepted at a clock edge, with out_ready held high, is presented with out_valid high after exactly 6 further rising edges.
- R4: With out_ready high, in_ready stays high, and a run of back-to-back accepted blocks leaves the block in the same number of consecutive cycles.
- R5: While out_valid is high and out_ready is low, the next cycle shows out_valid still high and out_dim and out_zero unchanged.
- R6: Starting from an empty pipeline with out_ready held low, exactly 6 blocks are accepted before in_ready falls. Blocks offered while in_ready is low are ignored. Accepted blocks leave in acceptance order, with none lost and none duplicated.
- R7: After reset, out_valid is low and in_ready is high.
- R8: An all-zero block gives zero flag 1 on every output lane.
- R9: A block with only bit j set gives lane k the nonzero value 42^((2k+1)j) mod 257.
- R10: An all-ones block gives lane k the sum of 42^((2k+1)j) over all 64 values of j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can take an input this cycle |
| in_bits | input | 64 | Coefficient bits, bit j is x_j |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_dim | output | 512 | Eight-bit fields, lane k at bits 8k+7:8k |
| out_zero | output | 64 | Zero flags, lane k at bit k |

## Verification
Several properties are checked on every cycle by the embedded properties. Each stage register holds its contents under stall, a stage only gains a valid entry after its predecessor offered one, and an accepted entry is always captured. Each butterfly keeps its zero flag unchanged through the twiddle, and a butterfly never yields a zero sum and a zero difference from operands that are not both zero. The arithmetic of each lane, the natural output order, the exact six-cycle latency, the fill depth of six, and block ordering under random back-pressure can only be shown by the bench. The bench compares every output vector against a direct quadratic evaluation of the twisted transform.

// File: rtl/ntt257_pkg.sv
package ntt257_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned MODV = 257;
   localparam int unsigned DW   = 8;

   // zero flag in the top bit, value-minus-one below it
   typedef struct packed {
      logic          z;
      logic [DW-1:0] d;
   } dm_t;

   function automatic int unsigned pow_mod(int unsigned base, int unsigned e);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < e; i++) r = (r * (base % MODV)) % MODV;
      return r;
   endfunction

   function automatic int unsigned bit_rev(int unsigned v, int unsigned bits);
      int unsigned r;
      r = 0;
      for (int unsigned i = 0; i < bits; i++) if (v[i]) r = r | (32'd1 << (bits - 1 - i));
      return r;
   endfunction

   // constant-operand product, folds to a 256-entry mapping per constant
   function automatic dm_t mul_const(dm_t a, int unsigned w);
      dm_t         r;
      int unsigned p;
      int unsigned pm1;
      r = '0;
      if (a.z) begin
         r.z = 1'b1;
      end else begin
         p   = ((int'(a.d) + 1) * w) % MODV;
         pm1 = p - 1;
         r.d = pm1[DW-1:0];
      end
      return r;
   endfunction
endpackage

// File: rtl/dm_adder.sv
module dm_adder
   import ntt257_pkg::*;
#(
   parameter bit SUBTRACT = 1'b0
) (
   input  dm_t a,
   input  dm_t b,
   output dm_t y
);
   timeunit 1ns;
   timeprecision 1ps;

   dm_t           b_eff;
   logic [DW:0]   t;
   logic [DW-1:0] s;

   // negation of a nonzero encoded value is the bitwise inverse of its field
   if (SUBTRACT) begin : g_neg
      assign b_eff = b.z ? b : dm_t'({1'b0, ~b.d});
   end else begin : g_pass
      assign b_eff = b;
   end

   always_comb begin
      t = {1'b0, a.d} + {1'b0, b_eff.d};
      // carry clear: add the implicit one; carry set: wrap absorbs it
      s = t[DW-1:0] + {{(DW-1){1'b0}}, ~t[DW]};
      if (a.z)                         y = b_eff;
      else if (b_eff.z)                y = a;
      else if (t == {1'b0, {DW{1'b1}}}) y = dm_t'({1'b1, {DW{1'b0}}});
      else                             y = dm_t'({1'b0, s});
   end
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly
   import ntt257_pkg::*;
#(
   parameter int unsigned TWIDDLE = 1
) (
   input  dm_t u,
   input  dm_t v,
   output dm_t s,
   output dm_t t
);
   timeunit 1ns;
   timeprecision 1ps;

   dm_t diff;

   if (TWIDDLE == 0 || TWIDDLE >= MODV) begin : g_bad_tw
      $error("twiddle must be a nonzero residue");
   end

   dm_adder #(.SUBTRACT(1'b0)) u_add (.a(u), .b(v), .y(s));
   dm_adder #(.SUBTRACT(1'b1)) u_sub (.a(u), .b(v), .y(diff));

   if (TWIDDLE == 1) begin : g_unity
      assign t = diff;
   end else begin : g_scale
      assign t = mul_const(diff, TWIDDLE);
   end

   always_comb begin
      assert_twiddle_zero_R2 : assert (t.z == diff.z);
      // modulus is odd, so sum and difference both zero force both operands zero
      assert_pair_zero_R2 : assert (!(s.z && diff.z) || (u.z && v.z));
   end
endmodule

// File: rtl/ntt_stage.sv
module ntt_stage
   import ntt257_pkg::*;
#(
   parameter  int unsigned LOG_N = 6,
   parameter  int unsigned OMEGA = 42,
   parameter  int unsigned STAGE = 0,
   localparam int unsigned N     = 1 << LOG_N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  dm_t [N-1:0]   in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output dm_t [N-1:0]   out_data
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned HALF = N >> (STAGE + 1);

   dm_t [N-1:0] bf_out;
   dm_t [N-1:0] d_q;
   logic        v_q;

   for (genvar b = 0; b < N / 2; b++) begin : g_bf
      localparam int unsigned GRP = b / HALF;
      localparam int unsigned J   = b % HALF;
      localparam int unsigned LO  = GRP * 2 * HALF + J;
      localparam int unsigned HI  = LO + HALF;
      localparam int unsigned TW  = pow_mod(OMEGA, 2 * J * (1 << STAGE));
      ntt_butterfly #(.TWIDDLE(TW)) u_bf (
         .u(in_data[LO]), .v(in_data[HI]), .s(bf_out[LO]), .t(bf_out[HI])
      );
   end

   assign in_ready  = !v_q || out_ready;
   assign out_valid = v_q;
   assign out_data  = d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
      end else if (in_ready) begin
         v_q <= in_valid;
         if (in_valid) d_q <= bf_out;
      end
   end

   assert_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && !out_ready) |=> (v_q && $stable(d_q)));
   assert_advance_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_q) |-> $past(in_valid));
   assert_take_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> v_q);
endmodule

// File: rtl/ntt257_pipe.sv
module ntt257_pipe
   import ntt257_pkg::*;
#(
   parameter  int unsigned LOG_N = 6,
   parameter  int unsigned OMEGA = 42,
   localparam int unsigned N     = 1 << LOG_N
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [N-1:0]    in_bits,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [N*DW-1:0] out_dim,
   output logic [N-1:0]    out_zero
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned NS = LOG_N;

   if (LOG_N < 1 || LOG_N > 7) begin : g_bad_size
      $error("transform order must divide 128");
   end
   if (pow_mod(OMEGA, N) != MODV - 1) begin : g_bad_root
      $error("omega must be a primitive root of order 2N");
   end

   dm_t [N-1:0] sd [NS+1];
   logic [NS:0] v;
   logic [NS:0] rdy;

   // pre-twist: a set bit selects omega^j, a clear bit selects zero
   for (genvar j = 0; j < N; j++) begin : g_twist
      localparam int unsigned W   = pow_mod(OMEGA, j);
      localparam int unsigned WM1 = W - 1;
      assign sd[0][j] = in_bits[j] ? dm_t'({1'b0, WM1[DW-1:0]})
                                   : dm_t'({1'b1, {DW{1'b0}}});
   end

   assign v[0]     = in_valid;
   assign in_ready = rdy[0];
   assign rdy[NS]  = out_ready;

   for (genvar s = 0; s < NS; s++) begin : g_stage
      ntt_stage #(.LOG_N(LOG_N), .OMEGA(OMEGA), .STAGE(s)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (v[s]),
         .in_ready (rdy[s]),
         .in_data  (sd[s]),
         .out_valid(v[s+1]),
         .out_ready(rdy[s+1]),
         .out_data (sd[s+1])
      );
   end

   assign out_valid = v[NS];

   // decimation in frequency leaves lane k at the bit-reversed slot
   for (genvar k = 0; k < N; k++) begin : g_order
      localparam int unsigned P = bit_rev(k, LOG_N);
      assign out_dim[k*DW +: DW] = sd[NS][P].d;
      assign out_zero[k]         = sd[NS][P].z;
   end

   assert_full_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));
endmodule

// File: tb/ntt257_pipe_bench.sv
module ntt257_pipe_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [63:0]  in_bits = '0;
   logic         out_ready = 1'b1;
   logic         in_ready;
   logic         out_valid;
   logic [511:0] out_dim;
   logic [63:0]  out_zero;

   ntt257_pipe u_ntt257_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
      .out_dim(out_dim), .out_zero(out_zero)
   );

   always #2.5 clk = ~clk;

   int          pw [128];
   logic [63:0] q_bits [512];
   string       q_tag [512];
   int          q_cyc [512];
   bit          q_lat [512];
   int          head = 0, tail = 0;
   int          n_cmp = 0, n_bad = 0, cyc = 0;
   int          r1_bad = 0, low_rdy_a = 0;
   int          first_out = -1, last_out = -1, cnt_lat = 0;
   bit          lat_en = 1'b0, rand_ready = 1'b0, prev_stall = 1'b0, done = 1'b0;
   logic [511:0] prev_dim;
   logic [63:0]  prev_zero;
   string       cur_tag = "R2";
   logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

   function automatic logic [63:0] nxt(logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   task automatic ref_lane(input logic [63:0] b, input int k, output logic ez, output logic [7:0] ed);
      int acc;
      acc = 0;
      for (int j = 0; j < 64; j++) if (b[j]) acc = (acc + pw[((2*k+1)*j) % 128]) % 257;
      ez = (acc == 0);
      ed = (acc == 0) ? 8'd0 : 8'(acc - 1);
   endtask

   task automatic check_out();
      logic ez, az;
      logic [7:0] ed, ad;
      logic [7:0] xd;
      logic xz;
      int bad_k;
      bad_k = -1;
      xd = 0; xz = 0; ad = 0; az = 0;
      if (head == tail) begin
         n_cmp++; n_bad++;
         $display("FAIL R6: output with no pending block, got z0=%0b expected none", out_zero[0]);
         return;
      end
      for (int k = 0; k < 64; k++) begin
         ref_lane(q_bits[head], k, ez, ed);
         if (bad_k < 0 && (out_zero[k] != ez || out_dim[k*8 +: 8] != ed)) begin
            bad_k = k; az = out_zero[k]; ad = out_dim[k*8 +: 8]; xz = ez; xd = ed;
         end
         if (out_zero[k] && out_dim[k*8 +: 8] != 8'd0) r1_bad++;
      end
      n_cmp++;
      if (bad_k >= 0) begin
         n_bad++;
         $display("FAIL %s: lane %0d got z=%0b d=%0d expected z=%0b d=%0d", q_tag[head], bad_k, az, ad, xz, xd);
      end
      if (q_lat[head]) begin
         n_cmp++;
         if (cyc - q_cyc[head] != 6) begin
            n_bad++;
            $display("FAIL R3: latency got %0d expected 6", cyc - q_cyc[head]);
         end
         if (first_out < 0) first_out = cyc;
         last_out = cyc;
         cnt_lat++;
      end
      head++;
   endtask

   // monitor: samples half a nanosecond before each rising edge
   initial forever begin
      @(negedge clk);
      #2;
      cyc++;
      if (rst_n) begin
         if (prev_stall) begin
            n_cmp++;
            if (!out_valid || out_dim != prev_dim || out_zero != prev_zero) begin
               n_bad++;
               $display("FAIL R5: held output changed, valid got %0b expected 1", out_valid);
            end
         end
         if (lat_en && !in_ready) low_rdy_a++;
         if (out_valid && out_ready) check_out();
         if (in_valid && in_ready && tail < 512) begin
            q_bits[tail] = in_bits; q_tag[tail] = cur_tag; q_cyc[tail] = cyc; q_lat[tail] = lat_en;
            tail++;
         end
         prev_stall = out_valid && !out_ready;
         prev_dim   = out_dim;
         prev_zero  = out_zero;
      end
   end

   initial forever begin
      @(negedge clk);
      if (rand_ready) begin
         rs = nxt(rs);
         out_ready = rs[5] | rs[9];
      end
   end

   task automatic send(input logic [63:0] b, input string tag);
      bit ok;
      ok = 1'b0;
      while (!ok) begin
         @(negedge clk);
         in_valid = 1'b1; in_bits = b; cur_tag = tag;
         #2 ok = in_ready;
         @(posedge clk);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not end, got cycle %0d expected completion", cyc);
         report();
      end
   end

   initial begin
      int acc_b;
      pw[0] = 1;
      for (int i = 1; i < 128; i++) pw[i] = (pw[i-1] * 42) % 257;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      n_cmp++;
      if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R7: out_valid got %0b expected 0", out_valid); end
      n_cmp++;
      if (in_ready !== 1'b1) begin n_bad++; $display("FAIL R7: in_ready got %0b expected 1", in_ready); end

      // phase A: free-flowing stream, latency and throughput
      lat_en = 1'b1;
      send(64'd0, "R8");
      for (int j = 0; j < 64; j++) send(64'd1 << j, "R9");
      send({64{1'b1}}, "R10");
      for (int i = 0; i < 30; i++) begin
         rs = nxt(rs);
         send(rs, "R2");
      end
      idle(1);
      lat_en = 1'b0;
      idle(12);
      n_cmp++;
      if (low_rdy_a != 0 || cnt_lat != 96 || last_out - first_out + 1 != 96) begin
         n_bad++;
         $display("FAIL R4: outputs %0d over span %0d, ready drops %0d, expected 96/96/0",
                  cnt_lat, last_out - first_out + 1, low_rdy_a);
      end

      // phase B: fill against a blocked consumer
      @(negedge clk);
      out_ready = 1'b0;
      acc_b = 0;
      for (int i = 0; i < 10; i++) begin
         if (i > 0) @(negedge clk);
         rs = nxt(rs);
         in_valid = 1'b1; in_bits = rs; cur_tag = "R6";
         #2 if (in_ready) acc_b++;
      end
      n_cmp++;
      if (acc_b != 6 || in_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R6: accepted %0d ready %0b, expected 6 and 0", acc_b, in_ready);
      end
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      idle(10);

      // phase C: random back-pressure and gaps
      rand_ready = 1'b1;
      for (int i = 0; i < 60; i++) begin
         rs = nxt(rs);
         send(rs, "R5");
         if (rs[3]) idle(int'(rs[12:11]) + 1);
      end
      idle(1);
      rand_ready = 1'b0;
      @(negedge clk);
      out_ready = 1'b1;
      idle(20);

      n_cmp++;
      if (head != tail) begin
         n_bad++;
         $display("FAIL R6: pending blocks got %0d expected 0", tail - head);
      end
      n_cmp++;
      if (r1_bad != 0) begin
         n_bad++;
         $display("FAIL R1: zero lanes with nonzero field got %0d expected 0", r1_bad);
      end
      done = 1'b1;
      report();
   end
endmodule